// File: doc/BRIEF.md
# Pin-limited UART with interrupts

A full-duplex serial port for a chip whose pads are few. Transmit bytes are presented on seven pins and land in bits 7..1 of the byte, bit 0 being forced to zero; a write strobe queues the byte in a four-entry FIFO. A separate load strobe, honoured only while the transmit enable is high, sends the oldest queued byte as one frame. The receiver watches the serial input, rejects glitches, checks parity and the stop bit, and presents each completed byte on an 8-bit output bus until a read strobe acknowledges it.

Bit time is derived from a fixed divisor of 32 clocks. With the rate-select input low each bit lasts 16 divisor periods (512 clocks) and the receiver finds mid-bit by oversampled counting. With it high each bit lasts one divisor period (32 clocks). Four interrupt lines and a busy flag report status.

Top module: `pin_uart`

## Requirements
- R1: After reset (rst_n low, active low) tx_line is 1, tx_busy is 0, tx_space_int is 1, rx_avail_int, tx_done_int and rx_event_int are 0 and rx_data is 0.
- R2: A transmitted frame is, in order, a low start bit, data bits 0 to 7 (least significant first) where bit 0 is 0 and bits 7..1 are the tx_hi7 value captured at the write, one parity bit, and a high stop bit; each bit lasts 512 clocks when fast_mode is 0 and 32 clocks when fast_mode is 1, and the idle line is high.
- R3: With par_odd 0 the parity bit equals the XOR of the eight data bits (even parity); with par_odd 1 it is the inverse (odd parity).
- R4: The transmit FIFO holds 4 bytes and sends them oldest first; a write while 4 are held is ignored, and tx_space_int is 0 exactly while 4 are held.
- R5: A load strobe starts one frame only when tx_en is 1, no frame is in progress and the FIFO is not empty; tx_busy is 1 from the start bit to the end of the stop bit.
- R6: tx_done_int pulses high for exactly one clock when the stop bit of a frame ends, the same edge at which tx_busy falls.
- R7: A received frame puts its data byte on rx_data and sets rx_avail_int; a rx_rd strobe clears rx_avail_int and leaves rx_data unchanged.
- R8: A low pulse on rx_in that has returned high by the middle of the start bit produces no frame and leaves rx_data and rx_avail_int untouched.
- R9: A parity mismatch (using par_odd as in R3) or a stop bit sampled low sets an error flag that holds rx_event_int high until a rx_rd strobe; a good frame only pulses rx_event_int for one clock.
- R10: If rx_rd is high in the clock in which a frame completes, the new frame wins: rx_avail_int stays 1 and rx_data shows the new byte.
- R11: With fast_mode 1 the receiver accepts frames whose bits last 32 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Reset, active low |
| tx_en | input | 1 | Transmit enable, gates the load strobe |
| par_odd | input | 1 | Parity select, 0 even, 1 odd |
| fast_mode | input | 1 | 1: 32 clocks per bit; 0: 512 clocks per bit (16x oversampled) |
| tx_wr | input | 1 | Queue the byte formed from tx_hi7 |
| tx_load | input | 1 | Start sending the oldest queued byte |
| rx_rd | input | 1 | Acknowledge the received byte and error |
| tx_hi7 | input | 7 | Bits 7..1 of the byte to queue |
| rx_in | input | 1 | Serial receive line |
| tx_line | output | 1 | Serial transmit line |
| tx_space_int | output | 1 | FIFO not full |
| rx_avail_int | output | 1 | Received byte waiting |
| tx_done_int | output | 1 | One-clock pulse at end of a sent frame |
| rx_event_int | output | 1 | Pulse at frame completion, held while an error is flagged |
| tx_busy | output | 1 | Frame being shifted out |
| rx_data | output | 8 | Last received byte |

## Verification
The read acknowledge and the completion of a new received frame can land in the same clock. The bench computes the exact edge at which the stop bit is sampled (two synchronizer stages, half a bit to the start-bit middle, then ten bit periods) and raises rx_rd for exactly that clock. It then judges that rx_avail_int is still set and rx_data carries the new byte, which a design letting the acknowledge win would fail.

// File: rtl/pin_uart.sv
module pin_uart #(
  parameter int DIV   = 32,
  parameter int OSR   = 16,
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_en,
  input  logic       par_odd,
  input  logic       fast_mode,
  input  logic       tx_wr,
  input  logic       tx_load,
  input  logic       rx_rd,
  input  logic [6:0] tx_hi7,
  input  logic       rx_in,
  output logic       tx_line,
  output logic       tx_space_int,
  output logic       rx_avail_int,
  output logic       tx_done_int,
  output logic       rx_event_int,
  output logic       tx_busy,
  output logic [7:0] rx_data
);
  localparam int BIT_SLOW = DIV * OSR;
  localparam int BIT_FAST = DIV;
  localparam int CW = $clog2(BIT_SLOW);
  localparam int AW = $clog2(DEPTH);
  localparam logic [CW-1:0] SLOW_LAST = CW'(BIT_SLOW - 1);
  localparam logic [CW-1:0] FAST_LAST = CW'(BIT_FAST - 1);
  localparam logic [CW-1:0] SLOW_HALF = CW'(BIT_SLOW / 2 - 1);
  localparam logic [CW-1:0] FAST_HALF = CW'(BIT_FAST / 2 - 1);

  typedef enum logic [1:0] {R_IDLE, R_START, R_BITS} rx_st_t;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   count;
  logic          full, push, pop;

  assign full         = (count == (AW+1)'(DEPTH));
  assign push         = tx_wr && !full;
  assign pop          = tx_load && tx_en && !tx_busy && (count != '0);
  assign tx_space_int = !full;

  always_ff @(posedge clk) if (push) mem[wp] <= {tx_hi7, 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      count <= count + (AW+1)'(push) - (AW+1)'(pop);
    end
  end

  logic [10:0]   tx_sh;
  logic [3:0]    tx_n;
  logic [CW-1:0] tx_cnt;
  logic          tx_fast;
  logic [CW-1:0] tx_last;
  logic [7:0]    head;

  assign head    = mem[rp];
  assign tx_last = tx_fast ? FAST_LAST : SLOW_LAST;
  assign tx_line = !tx_busy || tx_sh[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_busy <= 1'b0; tx_sh <= '1; tx_n <= '0; tx_cnt <= '0;
      tx_done_int <= 1'b0; tx_fast <= 1'b0;
    end else begin
      tx_done_int <= 1'b0;
      if (pop) begin
        tx_busy <= 1'b1;
        tx_sh   <= {1'b1, ^head ^ par_odd, head, 1'b0};
        tx_n    <= '0;
        tx_cnt  <= '0;
        tx_fast <= fast_mode;
      end else if (tx_busy) begin
        if (tx_cnt == tx_last) begin
          tx_cnt <= '0;
          if (tx_n == 4'd10) begin
            tx_busy     <= 1'b0;
            tx_done_int <= 1'b1;
          end else begin
            tx_n  <= tx_n + 1'b1;
            tx_sh <= {1'b1, tx_sh[10:1]};
          end
        end else tx_cnt <= tx_cnt + 1'b1;
      end
    end
  end

  logic          rx_s1, rx_s;
  rx_st_t        rx_st;
  logic [CW-1:0] rx_cnt;
  logic [3:0]    rx_n;
  logic [7:0]    rx_sh;
  logic          rx_fast, rx_pbad, rx_err, rx_done;
  logic [CW-1:0] rx_last, rx_half;

  assign rx_last      = rx_fast ? FAST_LAST : SLOW_LAST;
  assign rx_half      = rx_fast ? FAST_HALF : SLOW_HALF;
  assign rx_event_int = rx_done || rx_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_s1 <= 1'b1; rx_s <= 1'b1;
    end else begin
      rx_s1 <= rx_in; rx_s <= rx_s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_st <= R_IDLE; rx_cnt <= '0; rx_n <= '0; rx_sh <= '0;
      rx_fast <= 1'b0; rx_pbad <= 1'b0; rx_err <= 1'b0; rx_done <= 1'b0;
      rx_data <= '0; rx_avail_int <= 1'b0;
    end else begin
      rx_done <= 1'b0;
      if (rx_rd) begin
        rx_avail_int <= 1'b0;
        rx_err       <= 1'b0;
      end
      case (rx_st)
        R_IDLE: if (!rx_s) begin
          rx_st   <= R_START;
          rx_cnt  <= '0;
          rx_fast <= fast_mode;
        end
        R_START: if (rx_cnt == rx_half) begin
          rx_cnt <= '0;
          rx_n   <= '0;
          rx_st  <= rx_s ? R_IDLE : R_BITS;
        end else rx_cnt <= rx_cnt + 1'b1;
        default: if (rx_cnt == rx_last) begin
          rx_cnt <= '0;
          rx_n   <= rx_n + 1'b1;
          if (rx_n < 4'd8) rx_sh <= {rx_s, rx_sh[7:1]};
          else if (rx_n == 4'd8) rx_pbad <= (rx_s != (^rx_sh ^ par_odd));
          else begin
            rx_st        <= R_IDLE;
            rx_data      <= rx_sh;
            rx_avail_int <= 1'b1;
            rx_done      <= 1'b1;
            if (rx_pbad || !rx_s) rx_err <= 1'b1;
          end
        end else rx_cnt <= rx_cnt + 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/pin_uart_chk.sv
module pin_uart_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic tx_load,
  input logic rx_rd,
  input logic tx_line,
  input logic tx_space_int,
  input logic rx_avail_int,
  input logic tx_done_int,
  input logic rx_event_int,
  input logic tx_busy,
  input logic rx_err
);
  assert_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> tx_line);

  assert_full_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_space_int && !(tx_load && tx_en)) |=> !tx_space_int);

  assert_busy_from_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> $past(tx_load && tx_en));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done_int |=> !tx_done_int);

  assert_done_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done_int |-> (!tx_busy && $past(tx_busy)));

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rd |=> (!rx_avail_int || rx_event_int));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_err && !rx_rd) |=> rx_err);

  assert_err_drives_int_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err |-> rx_event_int);
endmodule

bind pin_uart pin_uart_chk chk_i (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_load(tx_load), .rx_rd(rx_rd),
  .tx_line(tx_line), .tx_space_int(tx_space_int), .rx_avail_int(rx_avail_int),
  .tx_done_int(tx_done_int), .rx_event_int(rx_event_int), .tx_busy(tx_busy),
  .rx_err(rx_err)
);

// File: tb/pin_uart_tb.sv
module pin_uart_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BIT_SLOW = 512;
  localparam int BIT_FAST = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_en = 1'b0, par_odd = 1'b0, fast_mode = 1'b0;
  logic tx_wr = 1'b0, tx_load = 1'b0, rx_rd = 1'b0, rx_in = 1'b1;
  logic [6:0] tx_hi7 = '0;
  logic tx_line, tx_space_int, rx_avail_int, tx_done_int, rx_event_int, tx_busy;
  logic [7:0] rx_data;

  int checks = 0, errors = 0, done_cnt = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (tx_done_int) done_cnt++;

  pin_uart dut_i (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end

  task automatic push(input logic [6:0] v);
    @(negedge clk); tx_hi7 = v; tx_wr = 1'b1;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic load();
    @(negedge clk); tx_load = 1'b1;
    @(negedge clk); tx_load = 1'b0;
  endtask

  task automatic decode(input int bitclk, output logic [10:0] bits);
    int guard = 0;
    bits = '1;
    while (tx_line && guard < 2000) begin @(negedge clk); guard++; end
    if (tx_line) return;
    repeat (bitclk/2) @(negedge clk);
    bits[0] = tx_line;
    for (int i = 1; i < 11; i++) begin
      repeat (bitclk) @(negedge clk);
      bits[i] = tx_line;
    end
  endtask

  task automatic send_rx(input logic [7:0] b, input bit bad_par, input bit bad_stop,
                         input int bitclk, input bit do_rd);
    @(negedge clk);
    fork
      begin
        rx_in = 1'b0;
        repeat (bitclk) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
          rx_in = b[i];
          repeat (bitclk) @(negedge clk);
        end
        rx_in = (^b ^ par_odd) ^ bad_par;
        repeat (bitclk) @(negedge clk);
        rx_in = !bad_stop;
        repeat (bitclk) @(negedge clk);
        rx_in = 1'b1;
      end
      begin
        if (do_rd) begin
          repeat (2 + bitclk/2 + 10*bitclk) @(posedge clk);
          @(negedge clk); rx_rd = 1'b1;
          @(negedge clk); rx_rd = 1'b0;
        end
      end
    join
  endtask

  task automatic read_ack();
    @(negedge clk); rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 tx_line", tx_line, 1);
    chk("R1 tx_busy", tx_busy, 0);
    chk("R1 tx_space", tx_space_int, 1);
    chk("R1 rx_avail", rx_avail_int, 0);
    chk("R1 ints", {tx_done_int, rx_event_int}, 0);
    chk("R1 rx_data", rx_data, 0);
  endtask

  task automatic t_tx_slow_even();
    logic [10:0] f;
    int d0;
    fast_mode = 0; par_odd = 0; tx_en = 1;
    push(7'h52);
    d0 = done_cnt;
    load();
    chk("R5 busy in frame", tx_busy, 1);
    decode(BIT_SLOW, f);
    chk("R2 start", f[0], 0);
    chk("R2 data slow", f[8:1], 8'hA4);
    chk("R3 even parity", f[9], 1);
    chk("R2 stop", f[10], 1);
    repeat (BIT_SLOW) @(negedge clk);
    chk("R6 busy end", tx_busy, 0);
    chk("R6 one done pulse", done_cnt - d0, 1);
  endtask

  task automatic t_tx_fast_odd();
    logic [10:0] f;
    fast_mode = 1; par_odd = 1; tx_en = 1;
    push(7'h7F);
    load();
    decode(BIT_FAST, f);
    chk("R2 data fast bit0 zero", f[8:1], 8'hFE);
    chk("R3 odd parity", f[9], 0);
    repeat (BIT_FAST) @(negedge clk);
  endtask

  task automatic t_fifo();
    logic [10:0] f;
    logic [6:0] vals [5] = '{7'h11, 7'h22, 7'h33, 7'h44, 7'h55};
    fast_mode = 1; par_odd = 0; tx_en = 0;
    for (int i = 0; i < 3; i++) push(vals[i]);
    chk("R4 space at 3", tx_space_int, 1);
    push(vals[3]);
    chk("R4 full at 4", tx_space_int, 0);
    push(vals[4]);
    load();
    repeat (3) @(negedge clk);
    chk("R5 load ignored when disabled", {tx_busy, tx_line}, 2'b01);
    tx_en = 1;
    for (int i = 0; i < 4; i++) begin
      load();
      decode(BIT_FAST, f);
      chk("R4 fifo order", f[8:1], {vals[i], 1'b0});
      while (tx_busy) @(negedge clk);
    end
    chk("R4 space after drain", tx_space_int, 1);
    load();
    repeat (3) @(negedge clk);
    chk("R4 write when full ignored", {tx_busy, tx_line}, 2'b01);
  endtask

  task automatic t_rx_slow();
    fast_mode = 0; par_odd = 0;
    send_rx(8'h3C, 0, 0, BIT_SLOW, 0);
    chk("R7 avail", rx_avail_int, 1);
    chk("R7 data", rx_data, 8'h3C);
    chk("R9 no error good frame", rx_event_int, 0);
    read_ack();
    chk("R7 read clears avail", rx_avail_int, 0);
    chk("R7 read keeps data", rx_data, 8'h3C);
  endtask

  task automatic t_rx_glitch();
    fast_mode = 0;
    @(negedge clk); rx_in = 0;
    repeat (20) @(negedge clk);
    rx_in = 1;
    repeat (12*BIT_SLOW) @(negedge clk);
    chk("R8 glitch no avail", rx_avail_int, 0);
    chk("R8 glitch data kept", rx_data, 8'h3C);
  endtask

  task automatic t_rx_fast();
    fast_mode = 1; par_odd = 1;
    send_rx(8'hC3, 0, 0, BIT_FAST, 0);
    chk("R11 fast data", rx_data, 8'hC3);
    chk("R11 fast avail no err", {rx_avail_int, rx_event_int}, 2'b10);
    read_ack();
  endtask

  task automatic t_rx_errors();
    fast_mode = 1; par_odd = 0;
    send_rx(8'h81, 1, 0, BIT_FAST, 0);
    chk("R9 parity err flagged", rx_event_int, 1);
    repeat (100) @(negedge clk);
    chk("R9 parity err sticky", rx_event_int, 1);
    read_ack();
    chk("R9 parity err cleared", {rx_event_int, rx_avail_int}, 0);
    send_rx(8'h0F, 0, 1, BIT_FAST, 0);
    repeat (4*BIT_FAST) @(negedge clk);
    chk("R9 stop err flagged", rx_event_int, 1);
    chk("R9 stop err data", rx_data, 8'h0F);
    read_ack();
    chk("R9 stop err cleared", rx_event_int, 0);
  endtask

  task automatic t_rx_collide();
    fast_mode = 1; par_odd = 0;
    send_rx(8'h5A, 0, 0, BIT_FAST, 1);
    repeat (2) @(negedge clk);
    chk("R10 completion beats read", rx_avail_int, 1);
    chk("R10 new data", rx_data, 8'h5A);
    read_ack();
  endtask

  initial begin
    t_reset();
    t_tx_slow_even();
    t_tx_fast_odd();
    t_fifo();
    t_rx_slow();
    t_rx_glitch();
    t_rx_fast();
    t_rx_errors();
    t_rx_collide();
    finish_run();
  end
endmodule